// File: doc/BRIEF.md
# Serial Video Scrambler and Serializer

This block converts a stream of 10-bit parallel video words into a serial bit stream, one bit per fast clock. The parallel and serial rates share one fast clock. A word is offered by pulsing `word_valid` once every ten cycles, so the serial rate is ten times the word rate. Before serialization, each word can be narrowed to 8 significant bits and clipped away from the reserved code ranges. The bit stream can then be scrambled by a self-synchronous x^9 + x^4 + 1 scrambler and, if selected, converted from NRZ to NRZI.

A plain mode turns the block into a bare parallel-to-serial converter. In this mode there is no clipping, no scrambling and no NRZI. When sync detection is on, the three words of a timing reference sequence go through without clipping. The sequence is an all-ones word followed by two all-zero words.

The serializer control has two states. `S_IDLE` moves to `S_SHIFT` when `word_valid` is seen. `S_SHIFT` counts ten bits. On its last bit it reloads and stays in `S_SHIFT` if `word_valid` is high; otherwise it returns to `S_IDLE`. The timing-reference tracker has three states, `T_NONE`, `T_PRE` and `T_ZERO1`. An accepted word whose upper 8 bits are all ones moves the tracker to `T_PRE`. An all-zero word moves `T_PRE` to `T_ZERO1`. Any other accepted word, and an all-zero word accepted in `T_ZERO1`, returns the tracker to `T_NONE`.

Top module: `svid_serializer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the scrambler history, the NRZI level, the bit counter and the tracker. `ser_bit` and `bit_valid` are 0 in the cycle after reset.
- R2: A word accepted at clock edge k produces `bit_valid` high after edges k+1 through k+10. If no new word is accepted on the last bit, `bit_valid` is low after edge k+11.
- R3: Bits are sent least-significant bit first. The bit shown after edge k+1+i is bit i of the conditioned word.
- R4: With `plain_mode`=1 the serial bits equal the input word bits unchanged. `nrzi_en` and `sync_en` have no effect, and the scrambler history is left untouched.
- R5: With `plain_mode`=0, each scrambled bit is s = d XOR h4 XOR h9. Here d is the data bit and hN is the scrambled bit sent N bits earlier (0 before any such bit).
- R6: With `plain_mode`=0 and `nrzi_en`=1, the output is an NRZI level that toggles on every scrambled 1 and starts from 0 after reset. With `nrzi_en`=0 the output is the scrambled bit itself.
- R7: With `narrow_en`=1, bits 1:0 of the word are forced to 0 before any other step.
- R8: With `plain_mode`=0, words 0x000 to 0x003 are sent as 0x004, unless they are timing-reference words.
- R9: With `plain_mode`=0, words 0x3FC to 0x3FF are sent as 0x3FB, unless they are timing-reference words.
- R10: With `sync_en`=1, the following words are timing-reference words and are sent unclipped: a word whose upper 8 bits are all ones, and an all-zero word (upper 8 bits zero) that follows such a word or follows one all-zero word after it.
- R11: With `sync_en`=0, no word is treated as a timing-reference word, so 0x3FF and 0x000 are clipped.
- R12: A `word_valid` pulse arriving while bits 0 to 8 of a word are being sent is ignored. The bit stream and the ten-bit `bit_valid` window are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | Parallel word strobe |
| word_in | input | 10 | Parallel video word |
| plain_mode | input | 1 | 1 = bare serializer, no clip/scramble/NRZI |
| nrzi_en | input | 1 | 1 = NRZI output after scrambling |
| narrow_en | input | 1 | 1 = 8-bit words, lower two bits forced to 0 |
| sync_en | input | 1 | 1 = exempt timing-reference words from clipping |
| ser_bit | output | 1 | Serial output bit |
| bit_valid | output | 1 | High when `ser_bit` carries a bit |

## Verification
Plain-mode words with a single set low bit and with alternating bits show the bit order and the untouched passthrough. Mid-range words sent through the scrambler, with and without NRZI, separate the tap positions and the toggle rule, because a wrong tap soon diverges from the expected history. Words just inside and just outside the reserved ranges, sent as full-width and as 8-bit words, separate clipping from narrowing. A timing-reference sequence sent with sync detection on and then off shows the exemption, and a stray strobe mid-word shows that strobes outside the last bit are ignored.

// File: rtl/svid_pkg.sv
package svid_pkg;
    typedef enum logic {S_IDLE, S_SHIFT} ser_state_t;
    typedef enum logic [1:0] {T_NONE, T_PRE, T_ZERO1} trs_state_t;
endpackage

// File: rtl/svid_word_cond.sv
module svid_word_cond
    import svid_pkg::*;
#(
    parameter int WORD_W   = 10,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [WORD_W-1:0] word_in,
    input  logic              narrow_en,
    input  logic              plain_mode,
    input  logic              sync_en,
    output logic [WORD_W-1:0] cond_word
);
    localparam int PAD_W = WORD_W - NARROW_W;
    localparam logic [WORD_W-1:0] LOW_LIM  = WORD_W'(4);
    localparam logic [WORD_W-1:0] HIGH_LIM = WORD_W'((1 << WORD_W) - 5);

    trs_state_t trs_q, trs_d;
    logic [WORD_W-1:0]   masked;
    logic [NARROW_W-1:0] upper;
    logic                is_ones, is_zero, pass;

    always_comb begin
        masked  = narrow_en ? {word_in[WORD_W-1:PAD_W], {PAD_W{1'b0}}} : word_in;
        upper   = masked[WORD_W-1:PAD_W];
        is_ones = &upper;
        is_zero = ~|upper;
        pass    = sync_en && (is_ones || (is_zero && trs_q != T_NONE));
    end

    always_comb begin
        trs_d = trs_q;
        if (accept) begin
            unique case (trs_q)
                T_NONE:  trs_d = is_ones ? T_PRE : T_NONE;
                T_PRE:   trs_d = is_ones ? T_PRE : (is_zero ? T_ZERO1 : T_NONE);
                T_ZERO1: trs_d = is_ones ? T_PRE : T_NONE;
                default: trs_d = T_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) trs_q <= T_NONE;
        else     trs_q <= trs_d;
    end

    always_comb begin
        cond_word = masked;
        if (!plain_mode && !pass) begin
            if (masked < LOW_LIM)       cond_word = LOW_LIM;
            else if (masked > HIGH_LIM) cond_word = HIGH_LIM;
        end
    end

    a_r8_clip_floor: assert property (@(posedge clk) disable iff (rst)
        (accept && !plain_mode && !sync_en) |-> (cond_word >= LOW_LIM));
    a_r9_clip_ceiling: assert property (@(posedge clk) disable iff (rst)
        (accept && !plain_mode && !sync_en) |-> (cond_word <= HIGH_LIM));
endmodule

// File: rtl/svid_bit_enc.sv
module svid_bit_enc #(
    parameter int SCR_LEN = 9,
    parameter int SCR_TAP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic data_bit,
    input  logic plain_mode,
    input  logic nrzi_en,
    output logic ser_bit,
    output logic bit_valid
);
    logic [SCR_LEN-1:0] hist_q;
    logic               nrzi_q, scr_bit;

    assign scr_bit = data_bit ^ hist_q[SCR_TAP-1] ^ hist_q[SCR_LEN-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q    <= '0;
            nrzi_q    <= 1'b0;
            ser_bit   <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            bit_valid <= fire;
            if (fire) begin
                if (plain_mode) begin
                    ser_bit <= data_bit;
                end else begin
                    hist_q  <= {hist_q[SCR_LEN-2:0], scr_bit};
                    nrzi_q  <= nrzi_q ^ scr_bit;
                    ser_bit <= nrzi_en ? (nrzi_q ^ scr_bit) : scr_bit;
                end
            end
        end
    end

    a_r6_nrzi_level: assert property (@(posedge clk) disable iff (rst)
        (fire && !plain_mode && nrzi_en) |=> (ser_bit == nrzi_q));
    a_r4_history_frozen: assert property (@(posedge clk) disable iff (rst)
        (fire && plain_mode) |=> $stable(hist_q));
endmodule

// File: rtl/svid_serializer.sv
module svid_serializer
    import svid_pkg::*;
#(
    parameter int WORD_W   = 10,
    parameter int NARROW_W = 8,
    parameter int SCR_LEN  = 9,
    parameter int SCR_TAP  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  logic              plain_mode,
    input  logic              nrzi_en,
    input  logic              narrow_en,
    input  logic              sync_en,
    output logic              ser_bit,
    output logic              bit_valid
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    ser_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shreg_q, cond_word;
    logic              load, fire;

    assign load = word_valid && (state_q == S_IDLE || cnt_q == LAST);
    assign fire = (state_q == S_SHIFT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (word_valid) state_d = S_SHIFT;
            S_SHIFT: if (cnt_q == LAST && !word_valid) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (load) begin
            cnt_q   <= '0;
            shreg_q <= cond_word;
        end else if (fire) begin
            cnt_q   <= cnt_q + 1'b1;
            shreg_q <= shreg_q >> 1;
        end
    end

    svid_word_cond #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_cond (
        .clk(clk), .rst(rst), .accept(load), .word_in(word_in),
        .narrow_en(narrow_en), .plain_mode(plain_mode), .sync_en(sync_en),
        .cond_word(cond_word)
    );

    svid_bit_enc #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_enc (
        .clk(clk), .rst(rst), .fire(fire), .data_bit(shreg_q[0]),
        .plain_mode(plain_mode), .nrzi_en(nrzi_en),
        .ser_bit(ser_bit), .bit_valid(bit_valid)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!bit_valid && !ser_bit));
    a_r2_first_bit: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && word_valid) |=> fire);
    a_r4_plain_pass: assert property (@(posedge clk) disable iff (rst)
        (fire && plain_mode) |=> (ser_bit == $past(shreg_q[0])));
    a_r12_mid_ignore: assert property (@(posedge clk) disable iff (rst)
        (fire && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: tb/tb_svid_serializer.sv
module tb_svid_serializer;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic word_valid = 1'b0;
    logic [9:0] word_in = '0;
    logic plain_mode = 1'b0, nrzi_en = 1'b0, narrow_en = 1'b0, sync_en = 1'b0;
    logic ser_bit, bit_valid;

    int n_chk = 0, n_bad = 0;
    logic [8:0] m_hist;
    logic       m_nrzi;
    int         m_trs;

    always #2.5 clk = ~clk;

    svid_serializer dut (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
        .plain_mode(plain_mode), .nrzi_en(nrzi_en), .narrow_en(narrow_en),
        .sync_en(sync_en), .ser_bit(ser_bit), .bit_valid(bit_valid)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [9:0] model_cond(input logic [9:0] w);
        logic [9:0] v;
        logic [7:0] up;
        logic pass;
        v    = narrow_en ? {w[9:2], 2'b00} : w;
        up   = v[9:2];
        pass = sync_en && ((up == 8'hFF) || (up == 8'h00 && m_trs != 0));
        if (up == 8'hFF)                     m_trs = 1;
        else if (up == 8'h00 && m_trs == 1)  m_trs = 2;
        else                                 m_trs = 0;
        if (!plain_mode && !pass) begin
            if (v < 10'h004)      v = 10'h004;
            else if (v > 10'h3FB) v = 10'h3FB;
        end
        return v;
    endfunction

    function automatic logic model_bit(input logic d);
        logic s;
        if (plain_mode) return d;
        s      = d ^ m_hist[3] ^ m_hist[8];
        m_hist = {m_hist[7:0], s};
        m_nrzi = m_nrzi ^ s;
        return nrzi_en ? m_nrzi : s;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; word_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        m_hist = '0; m_nrzi = 1'b0; m_trs = 0;
        check("R1 bit_valid", bit_valid, 1'b0);
        check("R1 ser_bit", ser_bit, 1'b0);
    endtask

    // Drives one word at the current negedge and checks all ten bits.
    task automatic send_word(input string req, input logic [9:0] w, input int junk_at);
        logic [9:0] cw;
        cw = model_cond(w);
        word_in = w; word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0; word_in = ~w;
        check("R2 no bit before first", bit_valid, 1'b0);
        for (int i = 0; i < 10; i++) begin
            if (i == junk_at) word_valid = 1'b1;
            @(negedge clk);
            word_valid = 1'b0;
            check("R2 window", bit_valid, 1'b1);
            check(req, ser_bit, model_bit(cw[i]));
        end
    endtask

    task automatic end_gap();
        @(negedge clk);
        check("R2 window closes", bit_valid, 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
    endtask

    task automatic t_plain();
        plain_mode = 1; nrzi_en = 1; sync_en = 1; narrow_en = 0;
        send_word("R3 lsb first", 10'h001, -1);
        send_word("R4 plain pass", 10'h2A5, -1);
        send_word("R4 plain no clip", 10'h3FE, -1);
        end_gap();
        plain_mode = 0; nrzi_en = 0; sync_en = 0;
    endtask

    task automatic t_scramble();
        do_reset();
        send_word("R5 scramble", 10'h200, -1);
        send_word("R5 scramble", 10'h155, -1);
        send_word("R5 scramble", 10'h3A0, -1);
        end_gap();
    endtask

    task automatic t_nrzi();
        do_reset();
        nrzi_en = 1;
        send_word("R6 nrzi", 10'h0F3, -1);
        send_word("R6 nrzi", 10'h26C, -1);
        end_gap();
        nrzi_en = 0;
    endtask

    task automatic t_narrow();
        narrow_en = 1; plain_mode = 1;
        send_word("R7 narrow", 10'h2B7, -1);
        plain_mode = 0;
        send_word("R7 narrow clip", 10'h003, -1);
        end_gap();
        narrow_en = 0;
    endtask

    task automatic t_clip();
        send_word("R8 clip low", 10'h002, -1);
        send_word("R8 clip low", 10'h000, -1);
        send_word("R9 clip high", 10'h3FD, -1);
        send_word("R9 clip high", 10'h3FC, -1);
        end_gap();
    endtask

    task automatic t_trs();
        sync_en = 1;
        send_word("R10 trs", 10'h3FF, -1);
        send_word("R10 trs", 10'h000, -1);
        send_word("R10 trs", 10'h000, -1);
        send_word("R10 after trs", 10'h000, -1);
        end_gap();
        sync_en = 0;
        send_word("R11 no sync", 10'h3FF, -1);
        send_word("R11 no sync", 10'h000, -1);
        end_gap();
    endtask

    task automatic t_ignore();
        send_word("R12 stray strobe", 10'h1C6, 4);
        end_gap();
    endtask

    initial begin
        t_reset();
        t_plain();
        t_scramble();
        t_nrzi();
        t_narrow();
        t_clip();
        t_trs();
        t_ignore();
        do_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule